// File: doc/BRIEF.md
# Dual-Mode Five-Input Lookup Table

This block is a configurable function generator built around a 32-bit truth table. Software-free configuration happens through a synchronous write port: when the write strobe is high at a rising clock edge, the whole 32-bit word replaces the table. Lookup is purely combinational. The four variables A, B, C and D drive two 16-way selectors, one over the lower half of the table and one over the upper half. Three 2-way selectors, steered by variable E and a mode bit, then form the two outputs.

With the mode bit low, the table is split into two independent four-variable functions, and E has no effect. With the mode bit high, the two halves join into one five-variable function that drives both outputs. A function of fewer variables is loaded by repeating its values over the inputs it does not use.

Top module: `dual_lut5`

## Requirements
- R1: With join_mode = 1, both outputs equal table entry number {var_e, var_a, var_b, var_c, var_d}, where var_e is the most significant bit and var_d the least. cfg_data bit i is entry i.
- R2: With join_mode = 0, res_lo equals entry {var_a, var_b, var_c, var_d} (entries 0 to 15) and res_hi equals entry 16 + {var_a, var_b, var_c, var_d} (entries 16 to 31).
- R3: With join_mode = 0, changing var_e alone leaves res_lo and res_hi unchanged.
- R4: With join_mode = 1, res_lo and res_hi are always equal.
- R5: When cfg_we is high at a rising clock edge, the table takes cfg_data, and outputs read the new table from that edge on.
- R6: When cfg_we is low at a rising clock edge, the table keeps its contents whatever cfg_data holds.
- R7: When rst is high at a rising clock edge, every entry is cleared to 0, even if cfg_we is high at the same edge.
- R8: Outputs follow changes of var_a to var_e and join_mode within the same cycle, with no clock edge in between.
- R9: Functions of three variables are realised by tables in which the unused inputs do not matter: full-adder sum and carry of A, B and C are produced together in split mode with var_d ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the table |
| cfg_we | input | 1 | Table write strobe |
| cfg_data | input | 32 | New table contents, bit i is entry i |
| var_a | input | 1 | Function variable A (index bit 3) |
| var_b | input | 1 | Function variable B (index bit 2) |
| var_c | input | 1 | Function variable C (index bit 1) |
| var_d | input | 1 | Function variable D (index bit 0) |
| var_e | input | 1 | Function variable E (index bit 4, join mode only) |
| join_mode | input | 1 | 1: one five-variable function, 0: two four-variable functions |
| res_lo | output | 1 | First function output |
| res_hi | output | 1 | Second function output |

## Verification
A wrong table bit shows at the outputs only when the inputs address that entry, so every one of the 32 indices is visited in join mode and all 16 per half in split mode, right after each load. A selector wired with swapped steering bits or halves gives a wrong output within the same cycle for some index, since lookup is combinational. A table that fails to load, hold or clear shows on the first lookup after the offending clock edge.

// File: rtl/lut5_pkg.sv
package lut5_pkg;
  // Number of variables decoding one half of the table.
  localparam int unsigned SEL_BITS   = 4;
  // Entries per half and in the whole table.
  localparam int unsigned HALF_DEPTH = 1 << SEL_BITS;
  localparam int unsigned TBL_DEPTH  = 2 * HALF_DEPTH;
  localparam int unsigned IDX_BITS   = SEL_BITS + 1;

  typedef logic [TBL_DEPTH-1:0]  table_t;
  typedef logic [HALF_DEPTH-1:0] half_t;
  typedef logic [SEL_BITS-1:0]   sel_t;

  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_JOIN  = 1'b1
  } mode_e;

  // Entry index: top variable on the most significant bit.
  function automatic logic [IDX_BITS-1:0] entry_index(input logic top, input sel_t low);
    return {top, low};
  endfunction

  // Lower half of a table.
  function automatic half_t lower_half(input table_t t);
    return t[HALF_DEPTH-1:0];
  endfunction

  // Upper half of a table.
  function automatic half_t upper_half(input table_t t);
    return t[TBL_DEPTH-1:HALF_DEPTH];
  endfunction
endpackage

// File: rtl/lut5_table_store.sv
module lut5_table_store
  import lut5_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_en,
  input  table_t wr_word,
  output table_t tbl_q,
  output logic   wr_fire
);
  table_t tbl_r;

  // A write is taken only when reset is not active.
  assign wr_fire = wr_en & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_r <= '0;
    end else if (wr_en) begin
      tbl_r <= wr_word;
    end
  end

  assign tbl_q = tbl_r;
endmodule

// File: rtl/lut5_sel_tree.sv
module lut5_sel_tree #(
  parameter int unsigned SEL_W = 4
) (
  input  logic [(1<<SEL_W)-1:0] leaves,
  input  logic [SEL_W-1:0]      sel,
  output logic                  pick
);
  localparam int unsigned LEAF_N = 1 << SEL_W;

  // Each level halves the candidates; level L is steered by sel[L].
  for (genvar lv = 0; lv < SEL_W; lv++) begin : g_lvl
    localparam int unsigned OUT_N = LEAF_N >> (lv + 1);
    logic [OUT_N-1:0] vec;
    for (genvar j = 0; j < OUT_N; j++) begin : g_node
      if (lv == 0) begin : g_leaf
        assign vec[j] = sel[lv] ? leaves[2*j+1] : leaves[2*j];
      end else begin : g_inner
        assign vec[j] = sel[lv] ? g_lvl[lv-1].vec[2*j+1] : g_lvl[lv-1].vec[2*j];
      end
    end
  end

  assign pick = g_lvl[SEL_W-1].vec[0];
endmodule

// File: rtl/lut5_mode_stage.sv
module lut5_mode_stage
  import lut5_pkg::*;
(
  input  logic  lo_pick,
  input  logic  hi_pick,
  input  logic  top_var,
  input  mode_e mode,
  output logic  joined,
  output logic  out_lo,
  output logic  out_hi
);
  // First 2-way selector: top variable chooses the half.
  assign joined = top_var ? hi_pick : lo_pick;

  // Second and third 2-way selectors: mode picks split or joined value.
  always_comb begin
    if (mode == MODE_JOIN) begin
      out_lo = joined;
      out_hi = joined;
    end else begin
      out_lo = lo_pick;
      out_hi = hi_pick;
    end
  end
endmodule

// File: rtl/dual_lut5.sv
module dual_lut5
  import lut5_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [TBL_DEPTH-1:0] cfg_data,
  input  logic                 var_a,
  input  logic                 var_b,
  input  logic                 var_c,
  input  logic                 var_d,
  input  logic                 var_e,
  input  logic                 join_mode,
  output logic                 res_lo,
  output logic                 res_hi
);
  table_t tbl_q;
  logic   wr_fire;
  sel_t   sel_abcd;
  logic   lo_pick;
  logic   hi_pick;
  logic   joined;
  mode_e  mode;

  assign sel_abcd = {var_a, var_b, var_c, var_d};
  assign mode     = mode_e'(join_mode);

  lut5_table_store u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_word (cfg_data),
    .tbl_q   (tbl_q),
    .wr_fire (wr_fire)
  );

  lut5_sel_tree #(.SEL_W(SEL_BITS)) u_sel_lo (
    .leaves (lower_half(tbl_q)),
    .sel    (sel_abcd),
    .pick   (lo_pick)
  );

  lut5_sel_tree #(.SEL_W(SEL_BITS)) u_sel_hi (
    .leaves (upper_half(tbl_q)),
    .sel    (sel_abcd),
    .pick   (hi_pick)
  );

  lut5_mode_stage u_mode (
    .lo_pick (lo_pick),
    .hi_pick (hi_pick),
    .top_var (var_e),
    .mode    (mode),
    .joined  (joined),
    .out_lo  (res_lo),
    .out_hi  (res_hi)
  );
endmodule

// File: rtl/dual_lut5_checker.sv
module dual_lut5_checker
  import lut5_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic [TBL_DEPTH-1:0] cfg_data,
  input logic                 var_a,
  input logic                 var_b,
  input logic                 var_c,
  input logic                 var_d,
  input logic                 var_e,
  input logic                 join_mode,
  input logic                 res_lo,
  input logic                 res_hi,
  input logic [TBL_DEPTH-1:0] tbl_q,
  input logic                 wr_fire
);
  logic seen_rst;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
    else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
  end

  logic [IDX_BITS-1:0] idx;
  assign idx = entry_index(var_e, {var_a, var_b, var_c, var_d});

  p_join_index_r1: assert property (@(posedge clk) disable iff (rst)
    join_mode |-> (res_lo == tbl_q[idx]));

  p_split_halves_r2: assert property (@(posedge clk) disable iff (rst)
    !join_mode |-> (res_lo == tbl_q[{1'b0, idx[SEL_BITS-1:0]}]) &&
                   (res_hi == tbl_q[{1'b1, idx[SEL_BITS-1:0]}]));

  p_split_ignore_e_r3: assert property (@(posedge clk) disable iff (rst)
    (!join_mode && $past(!join_mode) && $stable(tbl_q) &&
     $stable({var_a, var_b, var_c, var_d}) && !$stable(var_e))
    |-> ($stable(res_lo) && $stable(res_hi)));

  p_join_equal_r4: assert property (@(posedge clk) disable iff (rst)
    join_mode |-> (res_lo == res_hi));

  p_write_load_r5: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (tbl_q == $past(cfg_data)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(tbl_q));

  p_reset_clear_r7: assert property (@(posedge clk) disable iff (seen_rst !== 1'b1)
    rst |=> (tbl_q == '0));
endmodule

bind dual_lut5 dual_lut5_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_data  (cfg_data),
  .var_a     (var_a),
  .var_b     (var_b),
  .var_c     (var_c),
  .var_d     (var_d),
  .var_e     (var_e),
  .join_mode (join_mode),
  .res_lo    (res_lo),
  .res_hi    (res_hi),
  .tbl_q     (tbl_q),
  .wr_fire   (wr_fire)
);

// File: tb/dual_lut5_tb_top.sv
module dual_lut5_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        var_a = 0, var_b = 0, var_c = 0, var_d = 0, var_e = 0;
  logic        join_mode = 0;
  logic        res_lo, res_hi;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dual_lut5 dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .var_a(var_a), .var_b(var_b), .var_c(var_c), .var_d(var_d), .var_e(var_e),
    .join_mode(join_mode), .res_lo(res_lo), .res_hi(res_hi)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Index bits: e=4, a=3, b=2, c=1, d=0.
  task automatic apply(input logic [4:0] ix, input logic jm);
    {var_e, var_a, var_b, var_c, var_d} = ix;
    join_mode = jm;
    #1;
  endtask

  task automatic write_table(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_data = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] parity_table();
    logic [31:0] t;
    for (int i = 0; i < 32; i++) t[i] = ^i[4:0];
    return t;
  endfunction

  // Lower half: sum of A,B,C; upper half: carry of A,B,C; D ignored.
  function automatic logic [31:0] adder_table();
    logic [31:0] t;
    for (int j = 0; j < 16; j++) begin
      logic a, b, c;
      a = j[3]; b = j[2]; c = j[1];
      t[j]      = a ^ b ^ c;
      t[16 + j] = (a & b) | (b & c) | (a & c);
    end
    return t;
  endfunction

  task automatic t_reset_state();
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      apply(i[4:0], 1'b1);
      check("R7 reset clears", res_lo | res_hi, 1'b0);
    end
  endtask

  task automatic t_parity_join();
    logic [31:0] t;
    t = parity_table();
    write_table(t);
    for (int i = 0; i < 32; i++) begin
      apply(i[4:0], 1'b1);
      check("R1 join lookup lo", res_lo, ^i[4:0]);
      check("R4 join both equal", res_hi, res_lo);
    end
  endtask

  task automatic t_adder_split();
    write_table(adder_table());
    for (int i = 0; i < 32; i++) begin
      logic a, b, c;
      a = i[3]; b = i[2]; c = i[1];
      apply(i[4:0], 1'b0);
      check("R9 sum (R2 lower half)", res_lo, a ^ b ^ c);
      check("R9 carry (R2 upper half)", res_hi, (a & b) | (b & c) | (a & c));
    end
  endtask

  task automatic t_split_pattern();
    logic [31:0] t;
    t = 32'hA5C3_1E69;
    write_table(t);
    for (int j = 0; j < 16; j++) begin
      apply({1'b0, j[3:0]}, 1'b0);
      check("R2 lower entry", res_lo, t[j]);
      check("R2 upper entry", res_hi, t[16 + j]);
      apply({1'b1, j[3:0]}, 1'b0);
      check("R3 E ignored lo", res_lo, t[j]);
      check("R3 E ignored hi", res_hi, t[16 + j]);
    end
  endtask

  task automatic t_mode_comb();
    logic [31:0] t;
    t = 32'h0001_0000;
    write_table(t);
    apply(5'b10000, 1'b0);
    check("R8 split lo same cycle", res_lo, 1'b0);
    check("R8 split hi same cycle", res_hi, 1'b1);
    apply(5'b10000, 1'b1);
    check("R8 join lo same cycle", res_lo, 1'b1);
    apply(5'b00000, 1'b1);
    check("R8 E change same cycle", res_hi, 1'b0);
  endtask

  task automatic t_hold();
    logic [31:0] t;
    t = 32'h8000_0001;
    write_table(t);
    @(negedge clk);
    cfg_data = 32'h7FFF_FFFE;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      apply(i[4:0], 1'b1);
      check("R6 hold without strobe", res_lo, t[i]);
    end
  endtask

  task automatic t_write_timing();
    @(negedge clk);
    apply(5'b00011, 1'b1);
    cfg_we = 1'b1;
    cfg_data = 32'h0000_0008;
    #1;
    check("R5 old table before edge", res_lo, 1'b0);
    @(posedge clk);
    #1;
    check("R5 new table after edge", res_lo, 1'b1);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset_beats_write();
    @(negedge clk);
    rst = 1'b1;
    cfg_we = 1'b1;
    cfg_data = 32'hFFFF_FFFF;
    @(negedge clk);
    rst = 1'b0;
    cfg_we = 1'b0;
    for (int i = 0; i < 32; i++) begin
      apply(i[4:0], 1'b1);
      check("R7 reset over write", res_lo, 1'b0);
    end
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_parity_join();
    t_adder_split();
    t_split_pattern();
    t_mode_comb();
    t_hold();
    t_write_timing();
    t_reset_beats_write();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule